// File: doc/BRIEF.md
# Falling-Edge DMA Request Acceptance Controller

This block converts an active-low DMA request pin into single-transfer activation pulses for one DMA channel running one transfer per request. When the channel enable is high, the controller samples the synchronized pin on every clock. A low sample is latched as a pending request. The request is handed to the channel as a one-cycle activation pulse, but only when the bus reports that it is free and the request has been pending for a minimum number of cycles.

After an activation, the controller waits for two things before it re-arms: the pin must be seen high, and the write cycle of the current transfer must report completion. Only then does it look for a low level again. The trigger is therefore a falling edge, built from a high sample followed by a low sample. A pin that stays low never produces a second request.

A transfer-end input parks the controller in a terminal state. Dropping the enable returns it to the idle state. Bus arbitration and the transfer cycles themselves lie outside the block; they appear here only as the bus-free and write-done pulses.

Top module: `dreq_edge_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the idle state. `state_o` uses these codes: 0 idle, 1 armed (sampling for low), 2 pending, 3 clearing (sampling for high), 4 finished. During reset `act_o` is 0 and `state_o` reads 0.
- R2: In the idle state with `en_i` high, the controller moves to armed on the next cycle. The pin passes through SYNC_STAGES (default 2) flops. If the pin is driven low for the edge that ends cycle c, the state is still armed in cycles c+1 and c+2 and becomes pending in cycle c+3.
- R3: A pending request may activate only after it has been pending for MIN_GAP cycles (default 2). A bus-free input in the first pending cycle is ignored. With bus-free first high in pending cycle k (counted from 0), the activation happens in pending cycle max(k, MIN_GAP-1).
- R4: `act_o` is high for exactly one cycle. That cycle is one in which the state is pending and `bus_free_i` is high, and the next state is clearing. `bus_free_i` has no effect in any other state.
- R5: In clearing, the controller returns to armed after the edge on which both of these have been seen since clearing began: a high synchronized sample and a `wr_done_i` pulse. The two may arrive in either order or in the same cycle.
- R6: If the pin stays low through the write-done pulse, the controller stays in clearing and `act_o` stays 0. It re-arms only after the pin has returned high.
- R7: With `en_i` high, `xfer_end_i` moves any state to finished on the next cycle and suppresses `act_o` in that cycle. The controller stays in finished while `en_i` is high, whatever the other inputs do.
- R8: With `en_i` low, the next state is idle from any state, and this takes priority over `xfer_end_i`. `act_o` is 0 while `en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Channel enable level |
| req_n_i | input | 1 | Asynchronous active-low request pin |
| bus_free_i | input | 1 | Bus available for a DMA cycle |
| wr_done_i | input | 1 | DMA write cycle completed (pulse) |
| xfer_end_i | input | 1 | Transfer-end condition |
| act_o | output | 1 | One-cycle channel activation pulse |
| state_o | output | 3 | Controller state code |

## Verification
The bench sweeps the offset of the write-done pulse against the moment the pin returns high. A design that needed only one of the two, or that re-armed one cycle early or late, would move the expected armed cycle away from max(b+3, a+1). The bench also sweeps the arrival cycle of bus-free across the pending window, which catches a design that activates in the first pending cycle or counts the minimum gap from the wrong point. A pin held low across the write-done pulse must give no second pulse; an edge detector based on levels alone would fire again. The bench also checks that transfer-end suppresses a simultaneous activation, and that dropping the enable wins over transfer-end.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_ARM  = 3'd1,
      ST_HELD = 3'd2,
      ST_CLR  = 3'd3,
      ST_DONE = 3'd4
   } dreq_st_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
   parameter int STAGES = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL}};
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dreq_gap_cnt.sv
module dreq_gap_cnt #(
   parameter int MIN_GAP = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic ok_o
);
   generate
      if (MIN_GAP < 2) begin : g_nogap
         assign ok_o = 1'b1;
      end else begin : g_gap
         localparam int CNT_W = $clog2(MIN_GAP);
         localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_GAP - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || !run_i)  cnt_q <= '0;
            else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
         end
         assign ok_o = (cnt_q == LIM);
      end
   endgenerate
endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
   import dreq_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     en_i,
   input  logic     req_s_i,
   input  logic     gap_ok_i,
   input  logic     bus_free_i,
   input  logic     wr_done_i,
   input  logic     xfer_end_i,
   output logic     act_o,
   output dreq_st_e st_o
);
   dreq_st_e st_q, st_d;
   logic     hi_q, hi_d, wr_q, wr_d;

   always_comb begin
      st_d  = st_q;
      hi_d  = hi_q;
      wr_d  = wr_q;
      act_o = 1'b0;
      if (!en_i) begin
         st_d = ST_OFF;
      end else if (xfer_end_i) begin
         st_d = ST_DONE;
      end else begin
         unique case (st_q)
            ST_OFF:  st_d = ST_ARM;
            ST_ARM:  if (!req_s_i) st_d = ST_HELD;
            ST_HELD: if (bus_free_i && gap_ok_i) begin
                        act_o = 1'b1;
                        st_d  = ST_CLR;
                     end
            ST_CLR:  begin
                        hi_d = hi_q | req_s_i;
                        wr_d = wr_q | wr_done_i;
                        if (hi_d && wr_d) st_d = ST_ARM;
                     end
            ST_DONE: st_d = ST_DONE;
            default: st_d = ST_OFF;
         endcase
      end
      if (st_d != ST_CLR) begin
         hi_d = 1'b0;
         wr_d = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= ST_OFF;
         hi_q <= 1'b0;
         wr_q <= 1'b0;
      end else begin
         st_q <= st_d;
         hi_q <= hi_d;
         wr_q <= wr_d;
      end
   end

   assign st_o = st_q;
endmodule

// File: rtl/dreq_edge_ctrl.sv
module dreq_edge_ctrl
   import dreq_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MIN_GAP     = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en_i,
   input  logic       req_n_i,
   input  logic       bus_free_i,
   input  logic       wr_done_i,
   input  logic       xfer_end_i,
   output logic       act_o,
   output logic [2:0] state_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_GAP < 1) begin : g_bad_gap
         $error("MIN_GAP must be at least 1");
      end
   endgenerate

   logic     req_s;
   logic     gap_ok;
   dreq_st_e st;

   dreq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
      .clk (clk),
      .rst (rst),
      .d_i (req_n_i),
      .q_o (req_s)
   );

   dreq_gap_cnt #(.MIN_GAP(MIN_GAP)) gap_i (
      .clk   (clk),
      .rst   (rst),
      .run_i (st == ST_HELD),
      .ok_o  (gap_ok)
   );

   dreq_seq seq_i (
      .clk        (clk),
      .rst        (rst),
      .en_i       (en_i),
      .req_s_i    (req_s),
      .gap_ok_i   (gap_ok),
      .bus_free_i (bus_free_i),
      .wr_done_i  (wr_done_i),
      .xfer_end_i (xfer_end_i),
      .act_o      (act_o),
      .st_o       (st)
   );

   assign state_o = st;
endmodule

// File: rtl/dreq_edge_ctrl_chk.sv
module dreq_edge_ctrl_chk #(
   parameter int MIN_GAP = 2
) (
   input logic       clk,
   input logic       rst,
   input logic       en_i,
   input logic       bus_free_i,
   input logic       xfer_end_i,
   input logic       act_o,
   input logic [2:0] state_o
);
   p_act_in_held_r4: assert property (@(posedge clk) disable iff (rst)
      act_o |-> (state_o == 3'd2 && bus_free_i));

   p_act_then_clear_r4: assert property (@(posedge clk) disable iff (rst)
      act_o |=> (state_o == 3'd3));

   p_end_to_done_r7: assert property (@(posedge clk) disable iff (rst)
      (en_i && xfer_end_i) |=> (state_o == 3'd4));

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (en_i && state_o == 3'd4) |=> (state_o == 3'd4));

   p_off_when_disabled_r8: assert property (@(posedge clk) disable iff (rst)
      !en_i |=> (state_o == 3'd0));

   generate
      if (MIN_GAP >= 2) begin : g_gap_chk
         p_min_gap_r3: assert property (@(posedge clk) disable iff (rst)
            act_o |-> ($past(state_o) == 3'd2));
      end
   endgenerate
endmodule

bind dreq_edge_ctrl dreq_edge_ctrl_chk #(.MIN_GAP(MIN_GAP)) chk_i (
   .clk        (clk),
   .rst        (rst),
   .en_i       (en_i),
   .bus_free_i (bus_free_i),
   .xfer_end_i (xfer_end_i),
   .act_o      (act_o),
   .state_o    (state_o)
);

// File: tb/dreq_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
module dreq_edge_ctrl_tb_top;
   localparam logic [2:0] S_OFF = 3'd0, S_ARM = 3'd1, S_HELD = 3'd2,
                          S_CLR = 3'd3, S_DONE = 3'd4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic en = 1'b0, pin = 1'b1, bus = 1'b0, wr = 1'b0, xend = 1'b0;
   logic act;
   logic [2:0] st;
   int n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   dreq_edge_ctrl dut_i (
      .clk        (clk),
      .rst        (rst),
      .en_i       (en),
      .req_n_i    (pin),
      .bus_free_i (bus),
      .wr_done_i  (wr),
      .xfer_end_i (xfer_end_w),
      .act_o      (act),
      .state_o    (st)
   );
   logic xfer_end_w;
   assign xfer_end_w = xend;

   // One cycle: set inputs at the falling edge, then check this cycle's outputs.
   task automatic cyc(input logic e, input logic p, input logic b, input logic w,
                      input logic x, input logic [2:0] exp_st, input logic exp_act,
                      input string tag);
      @(negedge clk);
      en = e; pin = p; bus = b; wr = w; xend = x;
      #1;
      n_run++;
      if (st !== exp_st || act !== exp_act) begin
         n_fail++;
         $display("FAIL %s: state=%0d act=%0b expected state=%0d act=%0b",
                  tag, st, act, exp_st, exp_act);
      end
   endtask

   // Drive the pin low from an armed state; pending appears three cycles later.
   task automatic to_held(input string tag);
      for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, S_ARM, 0, tag);
   endtask

   initial begin
      #(200000 * 5.0);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1: reset state
      cyc(0, 1, 0, 0, 0, S_OFF, 0, "R1");
      cyc(0, 1, 1, 0, 0, S_OFF, 0, "R1");
      rst = 1'b0;
      cyc(0, 1, 1, 0, 0, S_OFF, 0, "R8");
      cyc(0, 1, 1, 0, 0, S_OFF, 0, "R8");
      // R2: enable arms on the next cycle
      cyc(1, 1, 0, 0, 0, S_OFF, 0, "R2");
      cyc(1, 1, 1, 0, 0, S_ARM, 0, "R4");
      cyc(1, 1, 1, 0, 0, S_ARM, 0, "R4");

      // Sweep: bus-free offset k, write-done offset a, pin-high offset b
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 4; b++) begin
            int k, actj, first;
            k     = (a + b) % 4;
            actj  = (k < 1) ? 1 : k;
            first = (b + 3 > a + 1) ? b + 3 : a + 1;
            to_held("R2");
            for (int j = 0; j <= actj; j++)
               cyc(1, 0, (j >= k), 0, 0, S_HELD, (j == actj), "R3");
            for (int c = 0; c <= first; c++)
               cyc(1, (c >= b), 1, (c == a), 0,
                   (c < first) ? S_CLR : S_ARM, 0, "R5");
         end
      end

      // R6: pin held low through write-done never re-triggers
      to_held("R2");
      cyc(1, 0, 1, 0, 0, S_HELD, 0, "R3");
      cyc(1, 0, 1, 0, 0, S_HELD, 1, "R4");
      for (int c = 0; c < 8; c++) cyc(1, 0, 1, (c == 0), 0, S_CLR, 0, "R6");
      for (int c = 0; c < 3; c++) cyc(1, 1, 1, 0, 0, S_CLR, 0, "R6");
      cyc(1, 1, 1, 0, 0, S_ARM, 0, "R6");

      // R7: transfer end suppresses activation and sticks
      to_held("R2");
      cyc(1, 0, 0, 0, 0, S_HELD, 0, "R3");
      cyc(1, 0, 1, 0, 1, S_HELD, 0, "R7");
      for (int c = 0; c < 4; c++) cyc(1, c[0], 1, 1, 0, S_DONE, 0, "R7");
      cyc(0, 1, 1, 0, 0, S_DONE, 0, "R8");
      cyc(1, 1, 0, 0, 0, S_OFF, 0, "R8");
      cyc(1, 1, 0, 0, 0, S_ARM, 0, "R2");

      // R8: enable low wins over transfer end
      to_held("R2");
      cyc(0, 0, 1, 0, 1, S_HELD, 0, "R8");
      for (int c = 0; c < 3; c++) cyc(0, 1, 1, 0, 0, S_OFF, 0, "R8");
      cyc(1, 1, 0, 0, 0, S_OFF, 0, "R8");
      cyc(1, 1, 0, 0, 0, S_ARM, 0, "R2");

      // R8: enable low during clearing
      to_held("R2");
      cyc(1, 0, 1, 0, 0, S_HELD, 0, "R3");
      cyc(1, 0, 1, 0, 0, S_HELD, 1, "R4");
      cyc(0, 0, 1, 0, 0, S_CLR, 0, "R8");
      cyc(0, 1, 1, 1, 0, S_OFF, 0, "R8");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule